// File: doc/BRIEF.md
# Time-Multiplexed Two-Read Two-Write Register File Model

This block behaves like a register file with two read ports and two write ports, where reads take no model time. Internally it uses only one storage array, and that array has a single write port. Each unit of simulated time is called a model cycle. One model cycle is spread across three clock cycles:

1. Both reads are served at once, from the contents as they stood before this model cycle.
2. The first write request is applied.
3. The second write request is applied.

A surrounding model starts a model cycle by pulsing a start strobe. It then waits for the done strobe, which says every request of that model cycle has been serviced and model time may advance. The block ignores a start strobe that arrives while a model cycle is still running. The read results stay on their outputs until the next start strobe that the block accepts.

Top module: `tm_regfile_2r2w`

## Requirements
- R1: After reset every register reads as zero, both read data outputs are zero and done is low.
- R2: The two read results of a model cycle reflect the contents from before that model cycle's writes, even when a write in the same model cycle targets the address being read.
- R3: Both read ports are served in the same model cycle and return independent registers; two reads of the same address both return that register's value.
- R4: An enabled write is visible to the reads of every later model cycle.
- R5: When both write ports are enabled for the same address, the value from write port 1 is the one kept.
- R6: A write port whose enable is low leaves the storage unchanged, and the model cycle still takes three clock cycles.
- R7: Take a start strobe accepted at clock edge k. Done is sampled high at edge k+3, and it is high for exactly one clock cycle. A start presented in the cycle where done is high is accepted, so model cycles can run back to back every three clock cycles.
- R8: Both read data outputs change only at a clock edge where a start strobe is accepted, and hold their value otherwise.
- R9: A start strobe seen while a model cycle is in progress is ignored. It produces no extra done pulse, and the write and read requests presented with it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a model cycle (accepted only when idle) |
| rd0_addr | input | ADDR_W | Read port 0 address |
| rd0_data | output | DATA_W | Read port 0 result, registered |
| rd1_addr | input | ADDR_W | Read port 1 address |
| rd1_data | output | DATA_W | Read port 1 result, registered |
| wr0_en | input | 1 | Write port 0 enable |
| wr0_addr | input | ADDR_W | Write port 0 address |
| wr0_data | input | DATA_W | Write port 0 data |
| wr1_en | input | 1 | Write port 1 enable (applied after port 0) |
| wr1_addr | input | ADDR_W | Write port 1 address |
| wr1_data | input | DATA_W | Write port 1 data |
| done | output | 1 | One-cycle pulse when the model cycle is complete |

## Verification
The hardest case to reach is a start strobe that lands in the middle of a running model cycle and carries its own write requests. If those writes leaked into the storage, nothing would show it until a later read. The stimulus re-asserts start one cycle after an accepted start, with a write of a distinctive value to a known register. It then checks two things: that only one done pulse appears, and that a following model cycle still reads the old value of that register. The same-address read-after-write case is produced by reading and writing one register within a single model cycle. The run then confirms that the old value comes back first and the new value comes back one model cycle later.

// File: rtl/tm_regfile_2r2w.sv
module tm_regfile_2r2w #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] rd0_addr,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [ADDR_W-1:0] rd1_addr,
  output logic [DATA_W-1:0] rd1_data,
  input  logic              wr0_en,
  input  logic [ADDR_W-1:0] wr0_addr,
  input  logic [DATA_W-1:0] wr0_data,
  input  logic              wr1_en,
  input  logic [ADDR_W-1:0] wr1_addr,
  input  logic [DATA_W-1:0] wr1_data,
  output logic              done
);

  typedef enum logic [1:0] {PH_IDLE, PH_WR0, PH_WR1} phase_t;

  phase_t            phase;
  logic [DATA_W-1:0] mem [DEPTH];

  logic              w0_en_q, w1_en_q;
  logic [ADDR_W-1:0] w0_addr_q, w1_addr_q;
  logic [DATA_W-1:0] w0_data_q, w1_data_q;

  wire idle   = (phase == PH_IDLE);
  wire accept = start && idle;

  wire              mem_we = (phase == PH_WR0 && w0_en_q) || (phase == PH_WR1 && w1_en_q);
  wire [ADDR_W-1:0] mem_wa = (phase == PH_WR1) ? w1_addr_q : w0_addr_q;
  wire [DATA_W-1:0] mem_wd = (phase == PH_WR1) ? w1_data_q : w0_data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      done <= (phase == PH_WR1);
      case (phase)
        PH_IDLE: if (start) phase <= PH_WR0;
        PH_WR0:  phase <= PH_WR1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w0_en_q   <= 1'b0;
      w1_en_q   <= 1'b0;
      w0_addr_q <= '0;
      w1_addr_q <= '0;
      w0_data_q <= '0;
      w1_data_q <= '0;
    end else if (accept) begin
      w0_en_q   <= wr0_en;
      w1_en_q   <= wr1_en;
      w0_addr_q <= wr0_addr;
      w1_addr_q <= wr1_addr;
      w0_data_q <= wr0_data;
      w1_data_q <= wr1_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd0_data <= '0;
      rd1_data <= '0;
    end else if (accept) begin
      rd0_data <= mem[rd0_addr];
      rd1_data <= mem[rd1_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (mem_we) begin
      mem[mem_wa] <= mem_wd;
    end
  end

  // R7: done arrives three edges after an accepted start
  p_done_latency_r7: assert property (@(posedge clk) disable iff (rst)
    accept |=> ##2 done);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: read results move only on an accepted start
  p_read_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(rd0_data) && $stable(rd1_data)));

  // R9: a start during a busy cycle must not disturb the captured writes
  p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !idle) |=> $stable({w0_en_q, w0_addr_q, w0_data_q, w1_en_q, w1_addr_q, w1_data_q}));

endmodule

// File: tb/sim_tm_regfile_2r2w.sv
`timescale 1ns/1ps
module sim_tm_regfile_2r2w;
  localparam int DW = 32;
  localparam int AW = 5;

  logic          clk = 0, rst = 1, start = 0;
  logic [AW-1:0] rd0_addr = 0, rd1_addr = 0, wr0_addr = 0, wr1_addr = 0;
  logic [DW-1:0] rd0_data, rd1_data, wr0_data = 0, wr1_data = 0;
  logic          wr0_en = 0, wr1_en = 0, done;

  logic [DW-1:0] gold [1<<AW];
  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tm_regfile_2r2w #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk, .rst, .start, .rd0_addr, .rd0_data, .rd1_addr, .rd1_data,
    .wr0_en, .wr0_addr, .wr0_data, .wr1_en, .wr1_addr, .wr1_data, .done);

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One model cycle, beginning on the current negedge; returns on the negedge where done is high.
  task automatic model_cycle(input logic [AW-1:0] ra0, ra1,
                             input logic e0, input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                             input logic e1, input logic [AW-1:0] a1, input logic [DW-1:0] d1);
    logic [DW-1:0] x0, x1;
    x0 = gold[ra0]; x1 = gold[ra1];
    rd0_addr = ra0; rd1_addr = ra1;
    wr0_en = e0; wr0_addr = a0; wr0_data = d0;
    wr1_en = e1; wr1_addr = a1; wr1_data = d1;
    start = 1;
    @(negedge clk); start = 0; wr0_en = 0; wr1_en = 0;
    chk("R7 done low 1", {31'b0, done}, 0);
    chk("R2 rd0 early", rd0_data, x0);
    @(negedge clk);
    chk("R7 done low 2", {31'b0, done}, 0);
    @(negedge clk);
    chk("R7 done high", {31'b0, done}, 1);
    chk("R2 R3 rd0", rd0_data, x0);
    chk("R2 R3 rd1", rd1_data, x1);
    if (e0) gold[a0] = d0;
    if (e1) gold[a1] = d1;
  endtask

  task automatic t_reset();
    chk("R1 rd0 reset", rd0_data, 0);
    chk("R1 rd1 reset", rd1_data, 0);
    chk("R1 done reset", {31'b0, done}, 0);
    model_cycle(5, 31, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_write_then_read();
    model_cycle(0, 1, 1, 3, 32'hAAAA0003, 1, 7, 32'h77770007);
    model_cycle(3, 7, 0, 0, 0, 0, 0, 0);
    chk("R4 reg3", rd0_data, 32'hAAAA0003);
    chk("R4 reg7", rd1_data, 32'h77770007);
  endtask

  task automatic t_same_cycle_rw();
    model_cycle(3, 3, 1, 3, 32'h0BAD0003, 0, 0, 0);
    chk("R2 old value", rd0_data, 32'hAAAA0003);
    chk("R3 same addr", rd1_data, 32'hAAAA0003);
    model_cycle(3, 9, 0, 0, 0, 0, 0, 0);
    chk("R4 new value", rd0_data, 32'h0BAD0003);
  endtask

  task automatic t_same_addr_writes();
    model_cycle(0, 0, 1, 12, 32'h11110000, 1, 12, 32'h22220000);
    model_cycle(12, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 port1 wins", rd0_data, 32'h22220000);
  endtask

  task automatic t_disabled_port();
    model_cycle(0, 0, 0, 7, 32'hDEADDEAD, 1, 20, 32'h20202020);
    model_cycle(7, 20, 1, 20, 32'h21212121, 0, 7, 32'hFEEDFEED);
    chk("R6 port0 off keeps reg7", rd0_data, 32'h77770007);
    chk("R6 port1 on", rd1_data, 32'h20202020);
    model_cycle(20, 7, 0, 0, 0, 0, 0, 0);
    chk("R6 port0 on", rd0_data, 32'h21212121);
    chk("R6 port1 off keeps reg7", rd1_data, 32'h77770007);
  endtask

  task automatic t_hold();
    @(negedge clk); @(negedge clk);
    chk("R8 hold rd0", rd0_data, 32'h21212121);
    chk("R8 hold rd1", rd1_data, 32'h77770007);
    chk("R7 single pulse", {31'b0, done}, 0);
  endtask

  task automatic t_busy_start();
    rd0_addr = 9; rd1_addr = 9; start = 1;
    @(negedge clk);
    rd0_addr = 7; rd1_addr = 20;
    wr0_en = 1; wr0_addr = 9; wr0_data = 32'h99999999;
    wr1_en = 1; wr1_addr = 9; wr1_data = 32'h98989898;
    @(negedge clk); start = 0; wr0_en = 0; wr1_en = 0;
    chk("R9 rd0 unaffected", rd0_data, 0);
    @(negedge clk);
    chk("R9 done once", {31'b0, done}, 1);
    @(negedge clk);
    chk("R9 no extra done", {31'b0, done}, 0);
    @(negedge clk);
    chk("R9 no extra done 2", {31'b0, done}, 0);
    model_cycle(9, 9, 0, 0, 0, 0, 0, 0);
    chk("R9 busy write dropped", rd0_data, 0);
  endtask

  task automatic t_back_to_back();
    model_cycle(1, 2, 1, 30, 32'h30303030, 1, 31, 32'h31313131);
    model_cycle(30, 31, 0, 0, 0, 0, 0, 0);
    chk("R7 back to back rd0", rd0_data, 32'h30303030);
    chk("R7 back to back rd1", rd1_data, 32'h31313131);
  endtask

  initial begin
    for (int i = 0; i < (1<<AW); i++) gold[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_write_then_read();
    t_same_cycle_rw();
    t_same_addr_writes();
    t_disabled_port();
    t_hold();
    t_busy_start();
    t_back_to_back();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule